// File: doc/BRIEF.md
# Packed BCD Add-With-Extend Unit

This block adds two packed two-digit decimal bytes together with an incoming extend bit. It produces a decimally corrected result byte and updates three condition flags: carry, extend and zero. Its operands are full-width words. Only the lowest byte of the destination word is replaced; the upper bits of the destination and every flag not named above pass through untouched. Encodings that are not valid BCD are not rejected. They go through the same correction arithmetic and do not raise any error.

The block is meant for chains of multi-precision decimal additions. The extend output of one step feeds the extend input of the next. The zero flag is sticky: a step can clear it but can never set it. Software therefore presets zero before a chain and reads it at the end to learn whether the whole multi-byte result was zero. Both the new destination word and the new flag word are captured in output registers on any clock edge where the valid strobe is high.

Top module: `bcd_xadd_unit`

## Requirements
- R1: The low digit sum is source bits 3:0 plus destination bits 3:0, plus one when the extend input is high.
- R2: The raw sum is the two upper nibbles added at their weighted position (bits 7:4), plus the low digit sum. Six is added to the raw sum when the low digit sum is greater than 9.
- R3: Take the sum after the R2 step and mask it to bits 9:4. If that masked value exceeds 0x90, add 0x60 and set carry (flag bit 0) and extend (flag bit 4) to one. Otherwise set both to zero. The intermediate is at least 10 bits wide.
- R4: Zero (flag bit 2) is cleared when the result byte is nonzero. Otherwise it keeps its input value. It is never set by the operation.
- R5: Output bits 7:0 hold the result byte. Bits DATA_W-1:8 equal the destination input bits.
- R6: Flag bits other than 0, 2 and 4 equal the corresponding bits of the incoming flag word.
- R7: Both outputs change only on a rising edge with the valid strobe high. Otherwise they hold their values.
- R8: A synchronous active-high reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe; loads the output registers |
| src_i | input | DATA_W | Source operand, low byte used |
| dst_i | input | DATA_W | Destination operand |
| xin_i | input | 1 | Incoming extend bit |
| flags_i | input | FLAG_W | Current flag word |
| res_o | output | DATA_W | Destination with low byte replaced |
| flags_o | output | FLAG_W | Updated flag word |

## Verification
Some cases are hard to reach from the ports because they need particular combinations of inputs. One is a nibble pair that is not valid BCD and pushes the intermediate past eight bits, such as 0xFF plus 0xFF with extend set. Another is a carry-out that leaves a zero byte while the incoming zero flag is clear, such as 0x50 plus 0x50. The bench reaches every such case by sweeping all source bytes, all destination bytes and both extend values, one operation per clock. Along the way it varies the upper destination bits and the incoming flag word, so passthrough and the sticky zero rule are tested against both flag polarities.

// File: rtl/bcd_xadd_pkg.sv
package bcd_xadd_pkg;

   localparam int BYTE_W    = 8;
   localparam int NIB_W     = 4;
   localparam int DIGIT_MAX = 9;
   localparam int MIN_INT_W = 10;

   typedef logic [NIB_W-1:0]  nibble_t;
   typedef logic [BYTE_W-1:0] byte_t;

   // true when both nibbles are decimal digits
   function automatic logic is_bcd_byte(input byte_t b);
      return (b[7:4] <= 4'(DIGIT_MAX)) && (b[3:0] <= 4'(DIGIT_MAX));
   endfunction

endpackage

// File: rtl/bcd_low_digit.sv
module bcd_low_digit
   import bcd_xadd_pkg::*;
#(
   parameter int INT_W = 10
)(
   input  nibble_t          a_nib,
   input  nibble_t          b_nib,
   input  logic             xin,
   output logic [INT_W-1:0] lo_sum,
   output logic             lo_adj
);

   localparam logic [INT_W-1:0] ADJ_LIMIT = INT_W'(DIGIT_MAX);

   always_comb begin
      lo_sum = INT_W'(a_nib) + INT_W'(b_nib) + INT_W'(xin);
      lo_adj = (lo_sum > ADJ_LIMIT);
   end

endmodule

// File: rtl/bcd_decade_fix.sv
module bcd_decade_fix
   import bcd_xadd_pkg::*;
#(
   parameter int INT_W = 10
)(
   input  byte_t            a_byte,
   input  byte_t            b_byte,
   input  logic [INT_W-1:0] lo_sum,
   input  logic             lo_adj,
   output byte_t            res_byte,
   output logic             carry
);

   localparam logic [INT_W-1:0] LO_FIX     = INT_W'(6);
   localparam logic [INT_W-1:0] HI_FIX     = INT_W'(8'h60);
   localparam logic [INT_W-1:0] TENS_MASK  = INT_W'(10'h3F0);
   localparam logic [INT_W-1:0] TENS_LIMIT = INT_W'(8'h90);

   logic [INT_W-1:0] hi_sum;
   logic [INT_W-1:0] raw_sum;
   logic [INT_W-1:0] step1;
   logic [INT_W-1:0] step2;

   always_comb begin
      hi_sum  = INT_W'({a_byte[7:4], 4'h0}) + INT_W'({b_byte[7:4], 4'h0});
      raw_sum = hi_sum + lo_sum;
      step1   = lo_adj ? (raw_sum + LO_FIX) : raw_sum;
      carry   = ((step1 & TENS_MASK) > TENS_LIMIT);
      step2   = carry ? (step1 + HI_FIX) : step1;
      res_byte = step2[7:0];
   end

endmodule

// File: rtl/bcd_flag_merge.sv
module bcd_flag_merge #(
   parameter int FLAG_W = 5,
   parameter int C_POS  = 0,
   parameter int Z_POS  = 2,
   parameter int X_POS  = 4
)(
   input  logic [FLAG_W-1:0] flags_in,
   input  logic              carry,
   input  logic              res_nz,
   output logic [FLAG_W-1:0] flags_nx
);

   always_comb begin
      flags_nx        = flags_in;
      flags_nx[C_POS] = carry;
      flags_nx[X_POS] = carry;
      if (res_nz)
         flags_nx[Z_POS] = 1'b0;
   end

endmodule

// File: rtl/bcd_xadd_unit.sv
module bcd_xadd_unit
   import bcd_xadd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int FLAG_W = 5,
   parameter int C_POS  = 0,
   parameter int Z_POS  = 2,
   parameter int X_POS  = 4,
   parameter int INT_W  = 10
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic              xin_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [DATA_W-1:0] res_o,
   output logic [FLAG_W-1:0] flags_o
);

   localparam logic [FLAG_W-1:0] OWN_MASK =
      (FLAG_W'(1) << C_POS) | (FLAG_W'(1) << Z_POS) | (FLAG_W'(1) << X_POS);
   localparam logic [FLAG_W-1:0] KEEP_MASK = ~OWN_MASK;

   // elaboration-time parameter checks
   generate
      if (DATA_W < BYTE_W) begin : g_bad_width
         $error("DATA_W must be at least one byte");
      end
      if (INT_W < MIN_INT_W) begin : g_bad_int
         $error("INT_W must be at least 10 bits");
      end
      if (C_POS >= FLAG_W || Z_POS >= FLAG_W || X_POS >= FLAG_W) begin : g_bad_pos
         $error("flag positions must lie inside the flag word");
      end
      if (C_POS == Z_POS || C_POS == X_POS || Z_POS == X_POS) begin : g_dup_pos
         $error("flag positions must be distinct");
      end
   endgenerate

   logic [INT_W-1:0]  lo_sum;
   logic              lo_adj;
   byte_t             res_byte;
   logic              carry;
   logic [FLAG_W-1:0] flags_nx;
   logic [DATA_W-1:0] dst_nx;

   bcd_low_digit #(.INT_W(INT_W)) u_low (
      .a_nib  (src_i[3:0]),
      .b_nib  (dst_i[3:0]),
      .xin    (xin_i),
      .lo_sum (lo_sum),
      .lo_adj (lo_adj)
   );

   bcd_decade_fix #(.INT_W(INT_W)) u_fix (
      .a_byte   (src_i[7:0]),
      .b_byte   (dst_i[7:0]),
      .lo_sum   (lo_sum),
      .lo_adj   (lo_adj),
      .res_byte (res_byte),
      .carry    (carry)
   );

   bcd_flag_merge #(
      .FLAG_W (FLAG_W),
      .C_POS  (C_POS),
      .Z_POS  (Z_POS),
      .X_POS  (X_POS)
   ) u_flags (
      .flags_in (flags_i),
      .carry    (carry),
      .res_nz   (|res_byte),
      .flags_nx (flags_nx)
   );

   // destination merge: pure byte or byte under passthrough bits
   generate
      if (DATA_W == BYTE_W) begin : g_byte_only
         assign dst_nx = res_byte;
      end else begin : g_wide
         assign dst_nx = {dst_i[DATA_W-1:BYTE_W], res_byte};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         res_o   <= '0;
         flags_o <= '0;
      end else if (in_valid) begin
         res_o   <= dst_nx;
         flags_o <= flags_nx;
      end
   end

   // R7
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(res_o) && $stable(flags_o)));

   // R3
   carry_extend_match_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (flags_o[C_POS] == flags_o[X_POS]));

   // R4
   zero_never_set_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> !(flags_o[Z_POS] && !$past(flags_i[Z_POS])));

   // R5
   upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (res_o[DATA_W-1:BYTE_W-1] ==
                    {$past(dst_i[DATA_W-1:BYTE_W]), res_o[BYTE_W-1]}));

   // R6
   other_flags_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ((flags_o & KEEP_MASK) == ($past(flags_i) & KEEP_MASK)));

   // R2
   bcd_in_bcd_out_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && is_bcd_byte(src_i[7:0]) && is_bcd_byte(dst_i[7:0]))
      |=> is_bcd_byte(res_o[7:0]));

   // R8
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (res_o == '0 && flags_o == '0));

endmodule

// File: tb/sim_bcd_xadd_unit.sv
`timescale 1ns/1ps
module sim_bcd_xadd_unit;

   localparam int DW = 32;
   localparam int FW = 5;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [DW-1:0] src_i;
   logic [DW-1:0] dst_i;
   logic          xin_i;
   logic [FW-1:0] flags_i;
   logic [DW-1:0] res_o;
   logic [FW-1:0] flags_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   bcd_xadd_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .src_i(src_i), .dst_i(dst_i), .xin_i(xin_i), .flags_i(flags_i),
      .res_o(res_o), .flags_o(flags_o)
   );

   task automatic check(input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected model built from the arithmetic requirements
   task automatic model(input int s, input int d, input int x,
                        input logic [FW-1:0] fi,
                        output logic [7:0] rb, output logic [FW-1:0] fo);
      int lo, hi, r, c;
      lo = (s & 15) + (d & 15) + x;               // R1
      hi = (s & 'hF0) + (d & 'hF0);
      r  = hi + lo;                               // R2
      if (lo > 9) r += 6;
      c  = ((r & 'h3F0) > 'h90) ? 1 : 0;          // R3
      if (c != 0) r += 'h60;
      rb = r[7:0];
      fo = fi;
      fo[0] = c[0];
      fo[4] = c[0];
      if (rb != 8'h00) fo[2] = 1'b0;              // R4
   endtask

   logic [DW-1:0] exp_res;
   logic [FW-1:0] exp_flg;
   bit            have_prev;

   task automatic check_prev();
      logic [FW-1:0] keep;
      keep = 5'b01010;
      check("R1 R2 R3 result byte", {24'h0, res_o[7:0]}, {24'h0, exp_res[7:0]});
      check("R5 upper bits", {res_o[DW-1:8], 8'h0}, {exp_res[DW-1:8], 8'h0});
      check("R3 carry/extend", {30'h0, flags_o[4], flags_o[0]},
            {30'h0, exp_flg[4], exp_flg[0]});
      check("R4 zero flag", {31'h0, flags_o[2]}, {31'h0, exp_flg[2]});
      check("R6 other flags", {27'h0, flags_o & keep}, {27'h0, exp_flg & keep});
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0]    rb;
      logic [FW-1:0] fo;
      rst = 1'b1; in_valid = 1'b0; src_i = '0; dst_i = '0;
      xin_i = 1'b0; flags_i = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8 reset state
      check("R8 reset result", res_o, '0);
      check("R8 reset flags", {27'h0, flags_o}, '0);

      have_prev = 1'b0;
      for (int x = 0; x < 2; x++) begin
         for (int s = 0; s < 256; s++) begin
            for (int d = 0; d < 256; d++) begin
               @(negedge clk);
               if (have_prev) check_prev();
               src_i   = {8'(s + 3 * d), 8'(d), 8'(s ^ 'h3C), 8'(s)};
               dst_i   = {8'(s), 8'(d ^ 'hC3), 8'(s + d + x), 8'(d)};
               xin_i   = x[0];
               flags_i = 5'((s * 7 + d + x) ^ (d >> 3));
               in_valid = 1'b1;
               model(s, d, x, flags_i, rb, fo);
               exp_res = {dst_i[DW-1:8], rb};
               exp_flg = fo;
               have_prev = 1'b1;
            end
         end
      end
      @(negedge clk);
      check_prev();

      // R7: idle strobe, inputs change, outputs must hold
      in_valid = 1'b0;
      src_i = 32'h1234_5678; dst_i = 32'hDEAD_0099; xin_i = 1'b1;
      flags_i = 5'b11111;
      repeat (3) @(negedge clk);
      check("R7 hold result", res_o, exp_res);
      check("R7 hold flags", {27'h0, flags_o}, {27'h0, exp_flg});

      // R8 mid-run reset
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R8 reset after run result", res_o, '0);
      check("R8 reset after run flags", {27'h0, flags_o}, '0);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   end

endmodule